// File: doc/BRIEF.md
# Power-up instruction gating controller

This block sits next to the instruction decoder of a serial memory device. After power is applied, it decides which classes of instruction the device may act on. Two comparator flags come in. One says the supply is above the write-inhibit threshold. The other says the supply has reached the minimum operating level. While the supply is below the inhibit threshold, the block holds the device logic in reset and no instruction is answered.

Two delays are counted in clock cycles, and each starts from a different supply crossing. The select delay starts when the minimum-level flag rises, and it opens the read gate. The power-up write delay starts when the inhibit flag rises. The modify gate opens only when both delays have completed, whichever completes last.

Each decoded instruction is answered with a one-cycle accept or reject strobe. On the first cycle out of reset, a one-cycle pulse clears the write-enable latch, so the device starts in standby with writes disabled.

Top module: `pwrup_gate`

## Requirements
- R1: While `inhibit_ok` is low, `int_rst` is high from the next clock edge on. `read_ok` and `modify_ok` are low, and neither strobe is produced.
- R2: Take the first rising clock edge that samples `inhibit_ok` high after reset. Counting that edge, the power-up write delay is complete after `PUW_CYC` such edges.
- R3: The select delay is complete after `SEL_CYC` edges that sample both `vmin_ok` and `inhibit_ok` high. `read_ok` goes high at that point, even if the power-up write delay is still running.
- R4: `modify_ok` is high only when both delays are complete, so it rises at the later of the two completions. A write-enable or modify instruction is never accepted while `modify_ok` is low.
- R5: `wel_clr` is high for exactly one cycle, right after the first clock edge that leaves reset. `int_rst` falls on that same edge.
- R6: When `inhibit_ok` falls, `read_ok` and `modify_ok` drop without waiting for a clock edge. `int_rst` rises at the next edge, and both delays restart from zero.
- R7: Driving `ext_rst_n` low puts the block in reset at once, whatever the supply flags say. Both delays restart after `ext_rst_n` is released.
- R8: If `vmin_ok` drops before the select delay completes, the select count restarts from zero.
- R9: The instruction class encoding on `instr_class` is as follows:
  - 00: read. Accepted whenever the read gate is open.
  - 01: write-enable. Accepted only while `modify_ok` is high, otherwise rejected.
  - 10: program, write or erase. Accepted only while `modify_ok` is high, otherwise rejected.
  - 11: reserved. Always rejected.
  
  The `accept` or `reject` strobe is registered and appears for one cycle after the edge that samples `instr_valid`. The two strobes are never high together.
- R10: `instr_valid` has no effect while `read_ok` is low or `cs_n` is high: neither strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| ext_rst_n | input | 1 | Asynchronous active-low external reset |
| inhibit_ok | input | 1 | Supply is above the write-inhibit threshold |
| vmin_ok | input | 1 | Supply is above the minimum operating level |
| cs_n | input | 1 | Chip select, active low |
| instr_valid | input | 1 | A decoded instruction is present this cycle |
| instr_class | input | 2 | Class of the decoded instruction (see R9) |
| int_rst | output | 1 | Internal reset for the device logic, active high |
| read_ok | output | 1 | Read instructions are permitted |
| modify_ok | output | 1 | Write-enable, program, write and erase instructions are permitted |
| accept | output | 1 | One-cycle strobe: the instruction is accepted |
| reject | output | 1 | One-cycle strobe: the instruction is rejected |
| wel_clr | output | 1 | One-cycle pulse that clears the write-enable latch |

## Verification
A delay counter holding a wrong value shows up at the gate flags. The gate edge moves away from the cycle predicted from the supply crossings, and this is visible at the first sampled cycle after the edge it should have opened on. The bench sweeps the arrival of the minimum-level flag from before the inhibit crossing to well after the power-up write delay. This sweep covers both orders in which the two delays can complete, and it checks both gates on every cycle of every case. A wrong gate decision appears as the wrong strobe one cycle after the instruction. A stale reset or latch-clear state appears on `int_rst` or `wel_clr` in the first cycle out of reset.

// File: rtl/pwg_pkg.sv
package pwg_pkg;

    typedef enum logic [1:0] {
        CLS_READ   = 2'b00,
        CLS_WREN   = 2'b01,
        CLS_MODIFY = 2'b10,
        CLS_RSVD   = 2'b11
    } instr_cls_e;

    typedef struct packed {
        logic acc;
        logic rej;
    } strobe_s;

    typedef struct packed {
        logic rst;
        logic wclr;
    } ctl_s;

endpackage

// File: rtl/pwg_delay.sv
module pwg_delay #(
    parameter int unsigned CYC = 8
) (
    input  logic clk,
    input  logic arst_n,
    input  logic clr,
    input  logic run,
    output logic done
);
    localparam int unsigned CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } dly_s;

    dly_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr || !run) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LIMIT) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign done = (st_q.cnt == LIMIT);

    // R8 / R6: a dropped flag or a clear restarts the count
    a_r8_restart: assert property (@(posedge clk) disable iff (!arst_n)
        (clr || !run) |=> !done);

    // R2: the count saturates at its limit
    a_r2_bound: assert property (@(posedge clk) disable iff (!arst_n)
        st_q.cnt <= LIMIT);

    // R3: completion only follows a cycle of running
    a_r3_rise: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(done) |-> $past(run && !clr));

endmodule

// File: rtl/pwg_cmd_gate.sv
module pwg_cmd_gate
    import pwg_pkg::*;
(
    input  logic       clk,
    input  logic       arst_n,
    input  logic       clr,
    input  logic       read_ok,
    input  logic       modify_ok,
    input  logic       cs_n,
    input  logic       instr_valid,
    input  logic [1:0] instr_class,
    output logic       accept,
    output logic       reject
);
    strobe_s st_d, st_q;

    always_comb begin
        st_d = '0;
        if (!clr && read_ok && !cs_n && instr_valid) begin
            unique case (instr_cls_e'(instr_class))
                CLS_READ: st_d.acc = 1'b1;
                CLS_WREN, CLS_MODIFY: begin
                    if (modify_ok) st_d.acc = 1'b1;
                    else           st_d.rej = 1'b1;
                end
                default: st_d.rej = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign accept = st_q.acc;
    assign reject = st_q.rej;

    // R9: strobes are mutually exclusive
    a_r9_excl: assert property (@(posedge clk) disable iff (!arst_n)
        !(accept && reject));

    // R10: nothing is decoded while the read gate is shut or chip is deselected
    a_r10_gated: assert property (@(posedge clk) disable iff (!arst_n)
        (!read_ok || cs_n || !instr_valid) |=> !(accept || reject));

    // R4: a write-class instruction is never accepted before the modify gate
    a_r4_no_early_modify: assert property (@(posedge clk) disable iff (!arst_n)
        (instr_valid && !modify_ok && instr_class != 2'b00) |=> !accept);

endmodule

// File: rtl/pwrup_gate.sv
module pwrup_gate
    import pwg_pkg::*;
#(
    parameter int unsigned PUW_CYC = 2000,
    parameter int unsigned SEL_CYC = 250
) (
    input  logic       clk,
    input  logic       ext_rst_n,
    input  logic       inhibit_ok,
    input  logic       vmin_ok,
    input  logic       cs_n,
    input  logic       instr_valid,
    input  logic [1:0] instr_class,
    output logic       int_rst,
    output logic       read_ok,
    output logic       modify_ok,
    output logic       accept,
    output logic       reject,
    output logic       wel_clr
);
    localparam ctl_s CTL_RST = '{rst: 1'b1, wclr: 1'b0};

    logic rst_all;
    logic pw_done;
    logic sl_done;
    ctl_s st_d, st_q;

    assign rst_all = !inhibit_ok;

    pwg_delay #(.CYC(PUW_CYC)) u_pw_dly (
        .clk    (clk),
        .arst_n (ext_rst_n),
        .clr    (rst_all),
        .run    (1'b1),
        .done   (pw_done)
    );

    pwg_delay #(.CYC(SEL_CYC)) u_sl_dly (
        .clk    (clk),
        .arst_n (ext_rst_n),
        .clr    (rst_all),
        .run    (vmin_ok),
        .done   (sl_done)
    );

    assign read_ok   = sl_done && !rst_all;
    assign modify_ok = read_ok && pw_done;

    always_comb begin
        st_d      = st_q;
        st_d.rst  = rst_all;
        st_d.wclr = st_q.rst && !rst_all;
    end

    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n) st_q <= CTL_RST;
        else            st_q <= st_d;
    end

    assign int_rst = st_q.rst;
    assign wel_clr = st_q.wclr;

    pwg_cmd_gate u_gate (
        .clk         (clk),
        .arst_n      (ext_rst_n),
        .clr         (rst_all),
        .read_ok     (read_ok),
        .modify_ok   (modify_ok),
        .cs_n        (cs_n),
        .instr_valid (instr_valid),
        .instr_class (instr_class),
        .accept      (accept),
        .reject      (reject)
    );

    // R1: below the inhibit threshold the device is held and silent
    a_r1_hold: assert property (@(posedge clk) disable iff (!ext_rst_n)
        !inhibit_ok |=> (int_rst && !accept && !reject));

    // R5: latch clear is a single pulse
    a_r5_pulse: assert property (@(posedge clk) disable iff (!ext_rst_n)
        wel_clr |=> !wel_clr);

    // R5: leaving reset always clears the write-enable latch
    a_r5_on_exit: assert property (@(posedge clk) disable iff (!ext_rst_n)
        $fell(int_rst) |-> wel_clr);

    // R6: after an inhibit drop, both gates start closed
    a_r6_restart: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (!inhibit_ok && vmin_ok) |=> !sl_done && !pw_done);

endmodule

// File: tb/pwrup_gate_test.sv
module pwrup_gate_test;
    localparam int P = 6;
    localparam int S = 3;

    logic       clk = 1'b0;
    logic       ext_rst_n = 1'b0;
    logic       inhibit_ok = 1'b0;
    logic       vmin_ok = 1'b0;
    logic       cs_n = 1'b1;
    logic       instr_valid = 1'b0;
    logic [1:0] instr_class = 2'b00;
    logic       int_rst, read_ok, modify_ok, accept, reject, wel_clr;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #2 clk = ~clk;

    pwrup_gate #(.PUW_CYC(P), .SEL_CYC(S)) uut (
        .clk(clk), .ext_rst_n(ext_rst_n), .inhibit_ok(inhibit_ok),
        .vmin_ok(vmin_ok), .cs_n(cs_n), .instr_valid(instr_valid),
        .instr_class(instr_class), .int_rst(int_rst), .read_ok(read_ok),
        .modify_ok(modify_ok), .accept(accept), .reject(reject),
        .wel_clr(wel_clr)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // issue one instruction at a negedge; check strobes after the next edge
    task automatic issue(input logic [1:0] cls, input logic csn,
                         input logic eacc, input logic erej, input string req);
        instr_valid = 1'b1;
        instr_class = cls;
        cs_n        = csn;
        step();
        instr_valid = 1'b0;
        cs_n        = 1'b1;
        chk({req, " accept"}, accept, eacc);
        chk({req, " reject"}, reject, erej);
    endtask

    // hold supplies low for a few cycles, checking the held state (R1)
    task automatic power_off();
        inhibit_ok = 1'b0;
        vmin_ok    = 1'b0;
        step();
        step();
        chk("R1 int_rst", int_rst, 1'b1);
        chk("R1 read_ok", read_ok, 1'b0);
        chk("R1 modify_ok", modify_ok, 1'b0);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        chk("R7 reset int_rst", int_rst, 1'b1);
        chk("R7 reset wel_clr", wel_clr, 1'b0);
        chk("R1 reset accept", accept, 1'b0);
        step();
        ext_rst_n = 1'b1;
        step();

        // Sweep the vmin arrival from before to after the inhibit crossing (R2 R3 R4 R5)
        for (int dv = -2; dv <= P + 2; dv++) begin
            power_off();
            if (dv < 0) begin
                vmin_ok = 1'b1;  // held in reset regardless (R1)
                step();
                chk("R1 vmin-first read_ok", read_ok, 1'b0);
                chk("R1 vmin-first int_rst", int_rst, 1'b1);
            end
            for (int k = 0; k <= P + S + 4; k++) begin
                inhibit_ok = 1'b1;
                if (k >= dv) vmin_ok = 1'b1;
                step();
                begin
                    int vs;
                    logic e_pw, e_sl;
                    vs   = (dv < 0) ? 0 : dv;
                    e_pw = ((k + 1) >= P);
                    e_sl = ((k + 1) >= vs + S);
                    chk("R3 read_ok timing", read_ok, e_sl);
                    chk("R2 R4 modify_ok timing", modify_ok, e_pw && e_sl);
                end
                if (k == 0) begin
                    chk("R5 int_rst fell", int_rst, 1'b0);
                    chk("R5 wel_clr pulse", wel_clr, 1'b1);
                end
                if (k == 1) chk("R5 wel_clr single", wel_clr, 1'b0);
            end
        end

        // R8: vmin glitch restarts the select count
        power_off();
        inhibit_ok = 1'b1;
        vmin_ok    = 1'b1;
        step();
        step();
        vmin_ok = 1'b0;
        step();
        vmin_ok = 1'b1;
        for (int i = 0; i < S - 1; i++) step();
        chk("R8 restart not yet", read_ok, 1'b0);
        step();
        chk("R8 restart opens", read_ok, 1'b1);

        // R10 / R9 window: no strobes before read gate, then read-only window
        power_off();
        inhibit_ok = 1'b1;
        vmin_ok    = 1'b1;
        issue(2'b00, 1'b0, 1'b0, 1'b0, "R10 read before gate");
        step();
        step();
        chk("R3 window read_ok", read_ok, 1'b1);
        chk("R4 window modify_ok", modify_ok, 1'b0);
        issue(2'b00, 1'b0, 1'b1, 1'b0, "R9 read in window");
        issue(2'b01, 1'b0, 1'b0, 1'b1, "R4 wren in window");
        issue(2'b10, 1'b0, 1'b0, 1'b1, "R4 modify in window");
        step();
        chk("R4 modify_ok open", modify_ok, 1'b1);
        issue(2'b01, 1'b0, 1'b1, 1'b0, "R9 wren open");
        issue(2'b10, 1'b0, 1'b1, 1'b0, "R9 modify open");
        issue(2'b11, 1'b0, 1'b0, 1'b1, "R9 reserved");
        issue(2'b00, 1'b1, 1'b0, 1'b0, "R10 deselected");

        // R6: inhibit drop closes gates at once, resets at next edge
        inhibit_ok = 1'b0;
        #1;
        chk("R6 read_ok immediate", read_ok, 1'b0);
        chk("R6 modify_ok immediate", modify_ok, 1'b0);
        issue(2'b00, 1'b0, 1'b0, 1'b0, "R1 instr during drop");
        chk("R6 int_rst", int_rst, 1'b1);
        inhibit_ok = 1'b1;
        for (int i = 0; i < P - 1; i++) step();
        chk("R6 restart not yet", modify_ok, 1'b0);
        step();
        chk("R6 restart opens", modify_ok, 1'b1);

        // R7: external reset overrides healthy supplies
        ext_rst_n = 1'b0;
        #1;
        chk("R7 int_rst async", int_rst, 1'b1);
        chk("R7 read_ok async", read_ok, 1'b0);
        step();
        step();
        chk("R7 held", int_rst, 1'b1);
        ext_rst_n = 1'b1;
        for (int i = 0; i < P - 1; i++) step();
        chk("R7 release modify not yet", modify_ok, 1'b0);
        chk("R7 release read_ok", read_ok, 1'b1);
        step();
        chk("R7 release modify opens", modify_ok, 1'b1);

        finish_run();
    end

endmodule